// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block applies a programmable gamma curve to the pixels of several display output channels. Each channel has three curves of 256 eight-bit entries, one for each of red, green and blue. All of them sit in a single packed table. The host fills the table through two write-only registers. The first is an address register that carries an auto-increment flag. The second is a data register whose upper byte is stored at the current address.

A pixel enters with its channel number and its three 8-bit components. Each component is used as an index into that channel's curve for the same colour, and the mapped pixel comes out one cycle later. Each channel has its own enable. When a channel's enable is clear, its pixels pass through unchanged and still take the same single cycle.

Top module: `gamma_lut`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and every entry of every curve holds its own index (entry i = i).
- R2: Flat address = ch × 768 + colour × 256 + index, with colour 0 = red, 1 = green and 2 = blue. A write to one segment leaves every other segment unchanged.
- R3: When `host_sel` = 1 the write goes to the data register, which stores `host_wdata[15:8]`. The low byte is discarded.
- R4: When `host_sel` = 0 the write goes to the address register. Bits [10:0] load the address and bit 15 sets the auto-increment flag. With the flag set, each data write stores one entry and then moves the address on by one.
- R5: With the flag clear, successive data writes all land on the same address.
- R6: Auto-increment from the last entry of the last channel (flat address 1535) wraps the address to 0.
- R7: With the channel's enable set, a pixel presented with `pix_valid` appears one cycle later on `out_valid` and the outputs, each component mapped through its curve. Without `pix_valid`, `out_valid` is 0 in the next cycle.
- R8: With `gamma_en[pix_ch]` clear, the outputs one cycle later equal the input components.
- R9: If a data write and a lookup reach the same entry in the same cycle, the lookup returns the value held before the write.
- R10: An address of 1536 or more is reduced modulo 1536 when it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 = address register, 1 = data register |
| host_wdata | input | HOST_W (16) | Host write value |
| gamma_en | input | NUM_CH (2) | Per-channel curve enable |
| pix_valid | input | 1 | Input pixel valid |
| pix_ch | input | CH_W (1) | Channel of the input pixel |
| pix_r | input | ENTRY_W (8) | Red component in |
| pix_g | input | ENTRY_W (8) | Green component in |
| pix_b | input | ENTRY_W (8) | Blue component in |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | ENTRY_W (8) | Red component out |
| out_g | output | ENTRY_W (8) | Green component out |
| out_b | output | ENTRY_W (8) | Blue component out |

## Verification
The hardest cases to reach from the ports are the wrap from the very last entry back to address 0, and a write and a lookup meeting on the same entry in the same cycle. For the wrap, the bench loads address 1535 with the flag set and issues two data writes. It then looks up blue index 255 of channel 1 and red index 0 of channel 0. For the collision, the bench raises a data write and a pixel aimed at the entry under the pointer in one cycle, then repeats the lookup in the next cycle to see the new value. A behavioural model of the flat table predicts every output cycle.

// File: rtl/gamma_lut_pkg.sv
// Shared definitions for the gamma lookup table.
// Assumes three colour segments per channel, in red, green, blue order.
package gamma_lut_pkg;
    localparam int COLOURS = 3;

    typedef enum logic [1:0] {
        COL_RED   = 2'd0,
        COL_GREEN = 2'd1,
        COL_BLUE  = 2'd2
    } colour_e;

    typedef enum logic {
        SEL_ADDR = 1'b0,
        SEL_DATA = 1'b1
    } host_reg_e;
endpackage

// File: rtl/gamma_lut_ptr.sv
// Host write pointer for the packed gamma table.
// Holds the current entry as separate channel, colour and index fields.
// An address-register write decodes the flat address, reduced modulo the
// table size. A data write advances the pointer when auto-increment is set.
// Assumes the flat address field is narrower than HOST_W, because the top
// bit of the host word carries the flag.
module gamma_lut_ptr #(
    parameter int NUM_CH  = 2,
    parameter int ENTRY_W = 8,
    parameter int HOST_W  = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_we,
    input  logic               data_we,
    input  logic [HOST_W-1:0]  wdata,
    output logic [CH_W-1:0]    ptr_ch,
    output logic [1:0]         ptr_col,
    output logic [ENTRY_W-1:0] ptr_idx,
    output logic               ptr_ainc
);
    import gamma_lut_pkg::*;

    localparam int ENTRIES = 1 << ENTRY_W;
    localparam int SEG     = COLOURS * ENTRIES;
    localparam int TOTAL   = NUM_CH * SEG;
    localparam int ADDR_W  = $clog2(TOTAL);

    logic [31:0] flat_w;
    logic [31:0] dec_ch_w;
    logic [31:0] dec_col_w;
    logic        last_idx, last_col, last_ch;

    // Reduce the written address into the table, then split it into fields.
    assign flat_w    = 32'(wdata[ADDR_W-1:0]) % 32'(TOTAL);
    assign dec_ch_w  = flat_w / 32'(SEG);
    assign dec_col_w = (flat_w / 32'(ENTRIES)) % 32'(COLOURS);

    assign last_idx = (ptr_idx == '1);
    assign last_col = (ptr_col == COL_BLUE);
    assign last_ch  = (ptr_ch == CH_W'(NUM_CH - 1));

    // Load on an address write; step with carry on an auto-increment data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_ch   <= '0;
            ptr_col  <= COL_RED;
            ptr_idx  <= '0;
            ptr_ainc <= 1'b0;
        end else if (addr_we) begin
            ptr_ch   <= dec_ch_w[CH_W-1:0];
            ptr_col  <= dec_col_w[1:0];
            ptr_idx  <= flat_w[ENTRY_W-1:0];
            ptr_ainc <= wdata[HOST_W-1];
        end else if (data_we && ptr_ainc) begin
            ptr_idx <= ptr_idx + ENTRY_W'(1);
            if (last_idx) begin
                if (last_col) begin
                    ptr_col <= COL_RED;
                    ptr_ch  <= last_ch ? '0 : ptr_ch + CH_W'(1);
                end else begin
                    ptr_col <= ptr_col + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/gamma_lut_bank.sv
// One colour's curves for all channels: NUM_CH segments of 2**ENTRY_W entries.
// Provides one write port and one registered read port. On a same-entry
// collision the read returns the old contents. Reset loads an identity ramp.
// Assumes NUM_CH is a power of two, so {ch, idx} addresses the bank densely.
module gamma_lut_bank #(
    parameter int NUM_CH  = 2,
    parameter int ENTRY_W = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_ch,
    input  logic [ENTRY_W-1:0] wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [CH_W-1:0]    rd_ch,
    input  logic [ENTRY_W-1:0] rd_idx,
    output logic [ENTRY_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << ENTRY_W;
    localparam int DEPTH   = NUM_CH * ENTRIES;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Ramp on reset; otherwise write, then register the read (old data wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= ENTRY_W'(i % ENTRIES);
            end
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                mem[{wr_ch, wr_idx}] <= wr_data;
            end
            rd_data <= mem[{rd_ch, rd_idx}];
        end
    end
endmodule

// File: rtl/gamma_lut.sv
// Top of the multi-channel gamma table: host register port, three colour
// banks and a one-cycle pixel pipeline with a per-channel bypass.
// Assumes pix_ch is below NUM_CH, and that a host word of HOST_W bits keeps
// its upper ENTRY_W bits as the stored entry.
module gamma_lut #(
    parameter int NUM_CH  = 2,
    parameter int ENTRY_W = 8,
    parameter int HOST_W  = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic               host_sel,
    input  logic [HOST_W-1:0]  host_wdata,
    input  logic [NUM_CH-1:0]  gamma_en,
    input  logic               pix_valid,
    input  logic [CH_W-1:0]    pix_ch,
    input  logic [ENTRY_W-1:0] pix_r,
    input  logic [ENTRY_W-1:0] pix_g,
    input  logic [ENTRY_W-1:0] pix_b,
    output logic               out_valid,
    output logic [ENTRY_W-1:0] out_r,
    output logic [ENTRY_W-1:0] out_g,
    output logic [ENTRY_W-1:0] out_b
);
    import gamma_lut_pkg::*;

    logic               addr_we, data_we;
    logic [CH_W-1:0]    ptr_ch;
    logic [1:0]         ptr_col;
    logic [ENTRY_W-1:0] ptr_idx;
    logic               ptr_ainc;
    logic [ENTRY_W-1:0] pix_comp [COLOURS];
    logic [ENTRY_W-1:0] map_q    [COLOURS];
    logic [ENTRY_W-1:0] pass_q   [COLOURS];
    logic               en_q;
    logic               valid_q;

    // Decode the host strobe into the two registers.
    assign addr_we = host_we && (host_sel == SEL_ADDR);
    assign data_we = host_we && (host_sel == SEL_DATA);

    // Gather the input components in colour order.
    assign pix_comp[COL_RED]   = pix_r;
    assign pix_comp[COL_GREEN] = pix_g;
    assign pix_comp[COL_BLUE]  = pix_b;

    gamma_lut_ptr #(
        .NUM_CH (NUM_CH),
        .ENTRY_W(ENTRY_W),
        .HOST_W (HOST_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_we (addr_we),
        .data_we (data_we),
        .wdata   (host_wdata),
        .ptr_ch  (ptr_ch),
        .ptr_col (ptr_col),
        .ptr_idx (ptr_idx),
        .ptr_ainc(ptr_ainc)
    );

    for (genvar c = 0; c < COLOURS; c++) begin : g_bank
        gamma_lut_bank #(
            .NUM_CH (NUM_CH),
            .ENTRY_W(ENTRY_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (data_we && (ptr_col == 2'(c))),
            .wr_ch  (ptr_ch),
            .wr_idx (ptr_idx),
            .wr_data(host_wdata[HOST_W-1 -: ENTRY_W]),
            .rd_ch  (pix_ch),
            .rd_idx (pix_comp[c]),
            .rd_data(map_q[c])
        );
    end

    // Register valid, the channel enable and the raw components alongside the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            en_q    <= 1'b0;
            for (int c = 0; c < COLOURS; c++) begin
                pass_q[c] <= '0;
            end
        end else begin
            valid_q <= pix_valid;
            en_q    <= gamma_en[pix_ch];
            for (int c = 0; c < COLOURS; c++) begin
                pass_q[c] <= pix_comp[c];
            end
        end
    end

    // Choose the mapped or the raw component for each colour.
    assign out_valid = valid_q;
    assign out_r     = en_q ? map_q[COL_RED]   : pass_q[COL_RED];
    assign out_g     = en_q ? map_q[COL_GREEN] : pass_q[COL_GREEN];
    assign out_b     = en_q ? map_q[COL_BLUE]  : pass_q[COL_BLUE];
endmodule

// File: rtl/gamma_lut_chk.sv
// Property checker for gamma_lut. It watches the pixel timing, the bypass
// path and the host pointer's stepping, holding and wrap-around.
module gamma_lut_chk #(
    parameter int NUM_CH  = 2,
    parameter int ENTRY_W = 8,
    parameter int HOST_W  = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_we,
    input logic               host_sel,
    input logic [NUM_CH-1:0]  gamma_en,
    input logic               pix_valid,
    input logic [CH_W-1:0]    pix_ch,
    input logic [ENTRY_W-1:0] pix_r,
    input logic [ENTRY_W-1:0] pix_g,
    input logic [ENTRY_W-1:0] pix_b,
    input logic               out_valid,
    input logic [ENTRY_W-1:0] out_r,
    input logic [ENTRY_W-1:0] out_g,
    input logic [ENTRY_W-1:0] out_b,
    input logic [CH_W-1:0]    ptr_ch,
    input logic [1:0]         ptr_col,
    input logic [ENTRY_W-1:0] ptr_idx,
    input logic               ptr_ainc
);
    logic data_wr;
    logic at_end;

    assign data_wr = host_we && host_sel;
    assign at_end  = (ptr_idx == '1) && (ptr_col == 2'd2)
                     && (ptr_ch == CH_W'(NUM_CH - 1));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !gamma_en[pix_ch]) |=>
        (out_r == $past(pix_r) && out_g == $past(pix_g) && out_b == $past(pix_b)));

    // R4
    ainc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ptr_ainc && ptr_idx != '1) |=>
        (ptr_idx == ENTRY_W'($past(ptr_idx) + 1'b1) && $stable(ptr_col) && $stable(ptr_ch)));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !ptr_ainc) |=>
        ($stable(ptr_idx) && $stable(ptr_col) && $stable(ptr_ch)));

    // R6
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ptr_ainc && at_end) |=>
        (ptr_idx == '0 && ptr_col == 2'd0 && ptr_ch == '0));
endmodule

bind gamma_lut gamma_lut_chk #(
    .NUM_CH (NUM_CH),
    .ENTRY_W(ENTRY_W),
    .HOST_W (HOST_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_we  (host_we),
    .host_sel (host_sel),
    .gamma_en (gamma_en),
    .pix_valid(pix_valid),
    .pix_ch   (pix_ch),
    .pix_r    (pix_r),
    .pix_g    (pix_g),
    .pix_b    (pix_b),
    .out_valid(out_valid),
    .out_r    (out_r),
    .out_g    (out_g),
    .out_b    (out_b),
    .ptr_ch   (ptr_ch),
    .ptr_col  (ptr_col),
    .ptr_idx  (ptr_idx),
    .ptr_ainc (ptr_ainc)
);

// File: tb/gamma_lut_bench.sv
`timescale 1ns/1ps
module gamma_lut_bench;
    localparam int TOTAL = 1536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  gamma_en = 2'b11;
    logic        pix_valid = 1'b0;
    logic [0:0]  pix_ch = '0;
    logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b;

    int checks = 0;
    int failures = 0;

    gamma_lut u_gamma_lut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .gamma_en(gamma_en), .pix_valid(pix_valid),
        .pix_ch(pix_ch), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    always #4 clk = ~clk;

    // Behavioural model: a flat table, a pointer and a flag.
    logic [7:0] mm [TOTAL];
    int         ptr;
    bit         ainc;
    bit         started = 0;
    bit         exp_v;
    logic [7:0] exp_r, exp_g, exp_b;
    string      cur_tag = "R1";
    string      exp_tag = "R1";

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mm[i] = 8'(i % 256);
            ptr = 0; ainc = 0; exp_v = 0;
        end else begin
            exp_v = pix_valid;
            exp_tag = cur_tag;
            if (pix_valid) begin
                int base;
                base = int'(pix_ch) * 768;
                if (gamma_en[pix_ch]) begin
                    exp_r = mm[base + int'(pix_r)];
                    exp_g = mm[base + 256 + int'(pix_g)];
                    exp_b = mm[base + 512 + int'(pix_b)];
                end else begin
                    exp_r = pix_r; exp_g = pix_g; exp_b = pix_b;
                end
            end
            if (host_we && !host_sel) begin
                ptr = int'(host_wdata[10:0]) % TOTAL;
                ainc = host_wdata[15];
            end else if (host_we && host_sel) begin
                mm[ptr] = host_wdata[15:8];
                if (ainc) ptr = (ptr + 1) % TOTAL;
            end
        end
        started = 1;
    end

    // Compare against the model in the middle of every clock period.
    always @(negedge clk) begin
        if (started && rst_n) begin
            check(exp_v ? exp_tag : "R7", int'(out_valid), int'(exp_v), "out_valid");
            if (exp_v) begin
                check(exp_tag, int'({out_r, out_g, out_b}),
                      int'({exp_r, exp_g, exp_b}), "rgb");
            end
        end
    end

    task automatic hw(input logic sel, input logic [15:0] d);
        host_we = 1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic px(input logic ch, input logic [7:0] r, g, b);
        pix_valid = 1; pix_ch = ch; pix_r = r; pix_g = g; pix_b = b;
        @(negedge clk);
        pix_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1", int'(out_valid), 0, "out_valid after reset");

        // R1: identity ramp on both channels, all colours
        cur_tag = "R1";
        for (int i = 0; i < 256; i++) px(1'b0, 8'(i), 8'(255 - i), 8'(i ^ 8'h5a));
        for (int i = 0; i < 256; i++) px(1'b1, 8'(i ^ 8'h33), 8'(i), 8'(255 - i));

        // R4: auto-increment fill of channel 1 green, low byte as junk
        cur_tag = "R4";
        hw(1'b0, 16'h8000 | 16'(768 + 256));
        for (int i = 0; i < 256; i++) hw(1'b1, {8'((i * 7 + 3) % 256), 8'hA5});
        // R3: upper byte stored, looked up on channel 1
        cur_tag = "R3";
        for (int i = 0; i < 256; i++) px(1'b1, 8'(i), 8'(i), 8'(i));
        // R2: channel 0 green untouched
        cur_tag = "R2";
        for (int i = 0; i < 256; i += 5) px(1'b0, 8'(i), 8'(i), 8'(i));

        // R5: no flag, repeated writes hit one entry
        cur_tag = "R5";
        hw(1'b0, 16'h000A);
        hw(1'b1, 16'h1100); hw(1'b1, 16'h2200); hw(1'b1, 16'h3300);
        px(1'b0, 8'd10, 8'd0, 8'd0);
        px(1'b0, 8'd11, 8'd0, 8'd0);

        // R6: wrap from the last entry to address 0
        cur_tag = "R6";
        hw(1'b0, 16'h8000 | 16'(TOTAL - 1));
        hw(1'b1, 16'h4400); hw(1'b1, 16'h5500);
        px(1'b1, 8'd0, 8'd0, 8'd255);
        px(1'b0, 8'd0, 8'd0, 8'd0);

        // R10: an address past the table is reduced modulo its size
        cur_tag = "R10";
        hw(1'b0, 16'h8000 | 16'(TOTAL + 5));
        hw(1'b1, 16'h6600);
        px(1'b0, 8'd5, 8'd5, 8'd5);

        // R8: channel 1 bypassed while channel 0 stays mapped
        cur_tag = "R8";
        gamma_en = 2'b01;
        for (int i = 0; i < 16; i++) px(1'b1, 8'(i * 3), 8'(i * 11), 8'(i * 13));
        px(1'b0, 8'd5, 8'd10, 8'd10);
        gamma_en = 2'b11;
        px(1'b1, 8'd9, 8'd9, 8'd9);

        // R9: a write and a lookup of the same entry in one cycle
        cur_tag = "R9";
        hw(1'b0, 16'h8000 | 16'd20);
        host_we = 1; host_sel = 1; host_wdata = 16'h7700;
        pix_valid = 1; pix_ch = 0; pix_r = 8'd20; pix_g = 8'd1; pix_b = 8'd2;
        @(negedge clk);
        host_we = 0;
        pix_r = 8'd20;
        @(negedge clk);
        pix_valid = 0;

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule